// File: doc/BRIEF.md
# Indexed-Access Prioritized Interrupt Controller

This block collects up to 128 interrupt request lines and presents one interrupt output to a processor. Every source carries its own priority, trigger type, vector word and enable bit. None of these has an address of its own. Software first writes a source number into a select register. Later accesses to the mode, vector and command registers then apply only to that source. The command registers take write-1 strobes that enable, disable, clear or software-set the selected source.

When software reads the vector register, the block acknowledges the winning source. It pushes that source's priority and number onto an 8-entry nesting stack, which masks all sources at or below that level. Each write to the end-of-interrupt register pops one level. When nothing is current, the vector read returns a programmable spurious word and changes no state. A status register reports the number of the source in service, so software can tell a real interrupt from a spurious one.

Top module: `irq_index_ctrl`

## Requirements
- R1: A write to offset 0x00 stores the source index from wdata[6:0], and a read returns it. Accesses at 0x04 and 0x08 reach only the source named by that index.
- R2: Offset 0x04 holds the selected source's priority in bits [2:0] (0 to 7, 7 highest) and its trigger type in bits [6:5]. The type codes are 00 active-high level, 01 rising edge, 10 active-low level and 11 falling edge. A read returns these fields with all other bits zero. Offset 0x08 holds a 32-bit vector word for the selected source, which reads back unchanged.
- R3: A write to 0x40 with wdata[0]=1 enables the selected source, and a write to 0x44 with wdata[0]=1 disables it. A command write with wdata[0]=0 has no effect. Bit 0 of a read at 0x30 returns the selected source's enable bit.
- R4: An edge-type source latches a pending flag on its active edge. A write of 1 to 0x4C latches that flag for the selected source, and a write of 1 to 0x48 clears it. A level-type source is pending exactly while its line is at the active level, and a clear command does not remove that.
- R5: A read at 0x20, 0x24, 0x28 or 0x2C returns word k, in which bit j is the pending state of source 32k+j, whatever its enable bit.
- R6: irq_o is high exactly when some enabled pending source has a priority strictly above the top of the nesting stack. When the stack is empty, any priority qualifies. Bit 0 of a read at 0x34 equals irq_o.
- R7: A read at 0x10 while irq_o is high returns the vector word of the enabled pending source with the highest priority. Among equal priorities, the lowest source number wins. The read pushes that source onto the nesting stack and clears its latched pending flag.
- R8: A read at 0x10 while irq_o is low returns the spurious word written at 0x3C and leaves the nesting stack unchanged.
- R9: A read at 0x18 returns the number of the source at the top of the nesting stack, or 0 when the stack is empty.
- R10: Any write to 0x38 pops one nesting level, and has no effect on an empty stack. Eight such writes always empty a full stack.
- R11: After reset, every register reads 0: the select index, each mode and vector word, the spurious word and the debug control bit at 0x6C. Also after reset, no source is enabled and irq_o is low. Bit 0 of 0x6C is writable and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; a read at 0x10 acknowledges |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| src_i | input | NSRC | Interrupt request lines, synchronous to clk |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Arbitration is tried with three source groups:
- A single level source, which separates live-line pending from latched pending and shows that enable gates the output.
- Two equal-priority edge sources with a higher one arriving mid-service, which tells the lowest-number tie-break apart from strict-greater preemption.
- An eight-step staircase of priorities 0 to 7, which fills the nesting stack and then unwinds it one end-of-interrupt at a time.

Falling-edge and active-low sources confirm the polarity codes. A vector read with nothing current is checked for the spurious word and for leaving the stack untouched.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;
  localparam logic [7:0] A_SEL  = 8'h00;
  localparam logic [7:0] A_MODE = 8'h04;
  localparam logic [7:0] A_VEC  = 8'h08;
  localparam logic [7:0] A_IVR  = 8'h10;
  localparam logic [7:0] A_ISR  = 8'h18;
  localparam logic [7:0] A_PND0 = 8'h20;
  localparam logic [7:0] A_PND1 = 8'h24;
  localparam logic [7:0] A_PND2 = 8'h28;
  localparam logic [7:0] A_PND3 = 8'h2C;
  localparam logic [7:0] A_MASK = 8'h30;
  localparam logic [7:0] A_CUR  = 8'h34;
  localparam logic [7:0] A_EOI  = 8'h38;
  localparam logic [7:0] A_SPU  = 8'h3C;
  localparam logic [7:0] A_EN   = 8'h40;
  localparam logic [7:0] A_DIS  = 8'h44;
  localparam logic [7:0] A_CLR  = 8'h48;
  localparam logic [7:0] A_SET  = 8'h4C;
  localparam logic [7:0] A_DBG  = 8'h6C;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  // level seen through the polarity bit of the trigger code
  function automatic logic line_active(logic lvl, logic [1:0] trig);
    return lvl ^ trig[1];
  endfunction

  // edge in the direction the trigger code asks for
  function automatic logic edge_seen(logic cur, logic prev, logic [1:0] trig);
    return trig[1] ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // a candidate preempts when the stack is empty or it is strictly higher
  function automatic logic preempts(logic [7:0] cand, logic busy, logic [7:0] top);
    return !busy || (cand > top);
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_idx_pkg::*;
#(
  parameter int NSRC   = 128,
  parameter int PRIO_W = 3,
  parameter int VEC_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NSRC-1:0]                 src_i,
  input  logic [$clog2(NSRC)-1:0]         sel_i,
  input  logic                            mode_we_i,
  input  logic                            vec_we_i,
  input  logic [31:0]                     wdata_i,
  input  logic                            en_cmd_i,
  input  logic                            dis_cmd_i,
  input  logic                            clr_cmd_i,
  input  logic                            set_cmd_i,
  input  logic                            ack_i,
  input  logic [$clog2(NSRC)-1:0]         ack_idx_i,
  output logic [NSRC-1:0]                 pend_o,
  output logic [NSRC-1:0]                 en_o,
  output logic [NSRC-1:0][PRIO_W-1:0]     prio_o,
  output logic [1:0]                      sel_trig_o,
  output logic [PRIO_W-1:0]               sel_prio_o,
  output logic [VEC_W-1:0]                sel_vec_o,
  output logic [VEC_W-1:0]                ack_vec_o
);
  localparam int IDX_W = $clog2(NSRC);

  logic [VEC_W-1:0] vec_w  [NSRC];
  logic [1:0]       trig_w [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic             hit, ack_hit, line_q, prev_q, flag_q, en_q;
    logic [1:0]       trig_q;
    logic [PRIO_W-1:0] prio_q;
    logic [VEC_W-1:0] vec_q;

    assign hit     = (sel_i == IDX_W'(g));
    assign ack_hit = ack_i && (ack_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q <= 1'b0;
        prev_q <= 1'b0;
        flag_q <= 1'b0;
        en_q   <= 1'b0;
        trig_q <= 2'b00;
        prio_q <= '0;
        vec_q  <= '0;
      end else begin
        line_q <= src_i[g];
        prev_q <= line_q;
        if (hit && en_cmd_i)       en_q <= 1'b1;
        else if (hit && dis_cmd_i) en_q <= 1'b0;
        if (hit && mode_we_i) begin
          trig_q <= wdata_i[6:5];
          prio_q <= wdata_i[PRIO_W-1:0];
        end
        if (hit && vec_we_i) vec_q <= wdata_i[VEC_W-1:0];
        if ((trig_q[0] && edge_seen(line_q, prev_q, trig_q)) || (hit && set_cmd_i))
          flag_q <= 1'b1;
        else if (ack_hit || (hit && clr_cmd_i))
          flag_q <= 1'b0;
      end
    end

    assign pend_o[g] = flag_q | (~trig_q[0] & line_active(line_q, trig_q));
    assign en_o[g]   = en_q;
    assign prio_o[g] = prio_q;
    assign vec_w[g]  = vec_q;
    assign trig_w[g] = trig_q;
  end

  assign sel_trig_o = trig_w[sel_i];
  assign sel_prio_o = prio_o[sel_i];
  assign sel_vec_o  = vec_w[sel_i];
  assign ack_vec_o  = vec_w[ack_idx_i];

  // R3
  en_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_cmd_i |=> en_o[$past(sel_i)]);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NSRC   = 128,
  parameter int PRIO_W = 3
) (
  input  logic [NSRC-1:0]             req_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic                        win_valid_o,
  output logic [$clog2(NSRC)-1:0]     win_idx_o,
  output logic [PRIO_W-1:0]           win_prio_o
);
  localparam int IDX_W = $clog2(NSRC);

  // ascending scan with a strict compare keeps the lowest index on a tie
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && (!win_valid_o || prio_i[i] > win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 7,
  parameter int PRIO_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [IDX_W-1:0]             push_idx_i,
  input  logic [PRIO_W-1:0]            push_prio_i,
  input  logic                         pop_i,
  output logic                         top_valid_o,
  output logic [IDX_W-1:0]             top_idx_o,
  output logic [PRIO_W-1:0]            top_prio_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  idx_q  [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [CW-1:0]     cnt_q, base;
  logic              pop_eff;
  logic [AW-1:0]     top_ptr;

  assign pop_eff = pop_i && (cnt_q != '0);
  assign base    = cnt_q - CW'(pop_eff);
  assign top_ptr = AW'(cnt_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        idx_q[i]  <= '0;
        prio_q[i] <= '0;
      end
    end else if (push_i) begin
      idx_q[AW'(base)]  <= push_idx_i;
      prio_q[AW'(base)] <= push_prio_i;
      cnt_q             <= base + CW'(1);
    end else begin
      cnt_q <= base;
    end
  end

  assign top_valid_o = (cnt_q != '0);
  assign top_idx_o   = top_valid_o ? idx_q[top_ptr]  : '0;
  assign top_prio_o  = top_valid_o ? prio_q[top_ptr] : '0;
  assign depth_o     = cnt_q;

  // R10
  nest_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && cnt_q == CW'(DEPTH)));
  // R7
  nest_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && top_valid_o) |-> (push_prio_i > top_prio_o));
  // R10
  nest_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/irq_index_ctrl.sv
module irq_index_ctrl
  import irq_idx_pkg::*;
#(
  parameter int NSRC   = 128,
  parameter int PRIO_W = 3,
  parameter int VEC_W  = 32,
  parameter int NEST   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr_i,
  input  logic            bus_rd_i,
  input  logic [7:0]      bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int CW    = $clog2(NEST + 1);

  logic [IDX_W-1:0]            sel_q;
  logic [31:0]                 spu_q;
  logic                        dbg_q;
  logic [NSRC-1:0]             pend, en;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic [1:0]                  sel_trig;
  logic [PRIO_W-1:0]           sel_prio;
  logic [VEC_W-1:0]            sel_vec, ack_vec;
  logic                        win_valid, top_valid, ack, eoi;
  logic [IDX_W-1:0]            win_idx, top_idx;
  logic [PRIO_W-1:0]           win_prio, top_prio;
  logic [CW-1:0]               nest_depth;
  logic [127:0]                pend_pad;

  function automatic logic wr_at(logic [7:0] a);
    return bus_wr_i && (bus_addr_i == a);
  endfunction

  assign ack = bus_rd_i && (bus_addr_i == A_IVR) && irq_o;
  assign eoi = wr_at(A_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      spu_q <= '0;
      dbg_q <= 1'b0;
    end else begin
      if (wr_at(A_SEL)) sel_q <= bus_wdata_i[IDX_W-1:0];
      if (wr_at(A_SPU)) spu_q <= bus_wdata_i;
      if (wr_at(A_DBG)) dbg_q <= bus_wdata_i[0];
    end
  end

  irq_src_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .sel_i      (sel_q),
    .mode_we_i  (wr_at(A_MODE)),
    .vec_we_i   (wr_at(A_VEC)),
    .wdata_i    (bus_wdata_i),
    .en_cmd_i   (wr_at(A_EN)  && bus_wdata_i[0]),
    .dis_cmd_i  (wr_at(A_DIS) && bus_wdata_i[0]),
    .clr_cmd_i  (wr_at(A_CLR) && bus_wdata_i[0]),
    .set_cmd_i  (wr_at(A_SET) && bus_wdata_i[0]),
    .ack_i      (ack),
    .ack_idx_i  (win_idx),
    .pend_o     (pend),
    .en_o       (en),
    .prio_o     (prio),
    .sel_trig_o (sel_trig),
    .sel_prio_o (sel_prio),
    .sel_vec_o  (sel_vec),
    .ack_vec_o  (ack_vec)
  );

  irq_prio_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i       (pend & en),
    .prio_i      (prio),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio)
  );

  irq_nest_stack #(.DEPTH(NEST), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_nest (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (ack),
    .push_idx_i  (win_idx),
    .push_prio_i (win_prio),
    .pop_i       (eoi),
    .top_valid_o (top_valid),
    .top_idx_o   (top_idx),
    .top_prio_o  (top_prio),
    .depth_o     (nest_depth)
  );

  assign irq_o = win_valid && preempts(8'(win_prio), top_valid, 8'(top_prio));

  assign pend_pad = 128'(pend);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_SEL:  bus_rdata_o = 32'(sel_q);
      A_MODE: begin
        bus_rdata_o[6:5]        = sel_trig;
        bus_rdata_o[PRIO_W-1:0] = sel_prio;
      end
      A_VEC:  bus_rdata_o = 32'(sel_vec);
      A_IVR:  bus_rdata_o = irq_o ? 32'(ack_vec) : spu_q;
      A_ISR:  bus_rdata_o = 32'(top_idx);
      A_PND0, A_PND1, A_PND2, A_PND3:
              bus_rdata_o = pend_pad[{bus_addr_i[3:2], 5'b0} +: 32];
      A_MASK: bus_rdata_o = {31'b0, en[sel_q]};
      A_CUR:  bus_rdata_o = {31'b0, irq_o};
      A_SPU:  bus_rdata_o = spu_q;
      A_DBG:  bus_rdata_o = {31'b0, dbg_q};
      default: bus_rdata_o = '0;
    endcase
  end

  // R7
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eoi) |=> (nest_depth == $past(nest_depth) + CW'(1)) && (top_idx == $past(win_idx)));
  // R8
  spur_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == A_IVR && !irq_o && !eoi) |=> $stable(nest_depth));
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && top_valid) |-> (win_prio > top_prio));
endmodule

// File: tb/test_irq_index_ctrl.sv
module test_irq_index_ctrl;
  localparam int NSRC = 128;
  localparam logic [1:0] T_HIGH = 2'b00, T_RISE = 2'b01, T_LOW = 2'b10, T_FALL = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] src = '0;
  logic            irq;
  int              checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_index_ctrl i_irq_index_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .src_i(src), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #5 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  task automatic expect_irq(string tag, logic exp);
    repeat (3) @(negedge clk);
    #5 check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  function automatic logic [31:0] vec_of(int s);
    return 32'h1000 + 32'(s);
  endfunction

  task automatic setup(int s, logic [1:0] trig, int p, bit enable);
    bus_write(8'h00, 32'(s));
    bus_write(8'h04, {25'b0, trig, 2'b00, 3'(p)});
    bus_write(8'h08, vec_of(s));
    if (enable) bus_write(8'h40, 32'h1);
  endtask

  task automatic off(int s);
    bus_write(8'h00, 32'(s));
    bus_write(8'h44, 32'h1);
  endtask

  task automatic t_reset;
    expect_reg("R11 select", 8'h00, 32'h0);
    expect_reg("R11 mode", 8'h04, 32'h0);
    expect_reg("R11 vector", 8'h08, 32'h0);
    expect_reg("R11 debug", 8'h6C, 32'h0);
    expect_reg("R11 mask", 8'h30, 32'h0);
    expect_reg("R9 empty status", 8'h18, 32'h0);
    expect_reg("R5 pending word3", 8'h2C, 32'h0);
    expect_irq("R11 irq", 1'b0);
    expect_reg("R8 spurious at reset", 8'h10, 32'h0);
  endtask

  task automatic t_regs;
    bus_write(8'h00, 32'h0000_0F85);
    bus_write(8'h04, 32'hFFFF_FF23);
    bus_write(8'h08, 32'hCAFE_0005);
    bus_write(8'h00, 32'd6);
    bus_write(8'h04, 32'h61);
    bus_write(8'h08, 32'h0000_0006);
    expect_reg("R1 select readback", 8'h00, 32'd6);
    expect_reg("R2 mode other source", 8'h04, 32'h61);
    bus_write(8'h00, 32'd5);
    expect_reg("R2 mode masked", 8'h04, 32'h23);
    expect_reg("R2 vector", 8'h08, 32'hCAFE_0005);
    bus_write(8'h6C, 32'h1);
    expect_reg("R11 debug write", 8'h6C, 32'h1);
    bus_write(8'h3C, 32'hDEAD_BEEF);
    expect_reg("R8 spurious reg", 8'h3C, 32'hDEAD_BEEF);
  endtask

  task automatic t_level;
    setup(10, T_HIGH, 2, 1'b1);
    src[10] = 1'b1;
    expect_irq("R6 level raise", 1'b1);
    expect_reg("R6 current status", 8'h34, 32'h1);
    expect_reg("R5 word0 bit10", 8'h20, 32'h400);
    expect_reg("R3 mask set", 8'h30, 32'h1);
    bus_write(8'h48, 32'h1);
    expect_reg("R4 clear keeps level", 8'h20, 32'h400);
    bus_write(8'h44, 32'h1);
    expect_irq("R3 disable", 1'b0);
    expect_reg("R3 mask clear", 8'h30, 32'h0);
    expect_reg("R5 pending while disabled", 8'h20, 32'h400);
    bus_write(8'h40, 32'h0);
    expect_irq("R3 zero data ignored", 1'b0);
    src[10] = 1'b0;
    bus_write(8'h40, 32'h1);
    expect_irq("R4 level follows line", 1'b0);
    off(10);
  endtask

  task automatic t_edge_ack;
    setup(40, T_RISE, 4, 1'b1);
    @(negedge clk) src[40] = 1'b1;
    @(negedge clk) src[40] = 1'b0;
    expect_irq("R4 rising latched", 1'b1);
    expect_reg("R5 word1 bit8", 8'h24, 32'h100);
    expect_reg("R7 vector read", 8'h10, vec_of(40));
    expect_irq("R6 in service masks", 1'b0);
    expect_reg("R9 status", 8'h18, 32'd40);
    expect_reg("R7 ack clears flag", 8'h24, 32'h0);
    bus_write(8'h38, 32'h0);
    expect_reg("R10 pop", 8'h18, 32'h0);
    off(40);
  endtask

  task automatic t_prio_nest;
    setup(20, T_RISE, 5, 1'b1);
    bus_write(8'h4C, 32'h1);
    setup(21, T_RISE, 5, 1'b1);
    bus_write(8'h4C, 32'h1);
    setup(30, T_RISE, 6, 1'b1);
    expect_reg("R7 tie lowest", 8'h10, vec_of(20));
    expect_reg("R9 status 20", 8'h18, 32'd20);
    expect_irq("R6 equal no preempt", 1'b0);
    bus_write(8'h4C, 32'h1);
    expect_irq("R6 higher preempts", 1'b1);
    expect_reg("R7 nested vector", 8'h10, vec_of(30));
    expect_reg("R9 status 30", 8'h18, 32'd30);
    bus_write(8'h38, 32'h0);
    expect_reg("R10 back to 20", 8'h18, 32'd20);
    expect_irq("R6 still masked", 1'b0);
    bus_write(8'h38, 32'h0);
    expect_irq("R6 released", 1'b1);
    expect_reg("R7 second of tie", 8'h10, vec_of(21));
    bus_write(8'h38, 32'h0);
    off(20); off(21); off(30);
    expect_irq("R6 all off", 1'b0);
  endtask

  task automatic t_spurious;
    expect_reg("R8 spurious word", 8'h10, 32'hDEAD_BEEF);
    expect_reg("R8 no push", 8'h18, 32'h0);
    bus_write(8'h38, 32'h0);
    expect_reg("R10 empty pop", 8'h18, 32'h0);
  endtask

  task automatic t_clear;
    setup(50, T_RISE, 1, 1'b1);
    bus_write(8'h4C, 32'h1);
    expect_irq("R4 software set", 1'b1);
    bus_write(8'h48, 32'h1);
    expect_irq("R4 clear command", 1'b0);
    expect_reg("R5 cleared bit", 8'h24, 32'h0);
    off(50);
  endtask

  task automatic t_unwind;
    logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      setup(60 + k, T_RISE, k, 1'b1);
      bus_write(8'h4C, 32'h1);
      bus_read(8'h10, d);
      check("R7 staircase vector", d, vec_of(60 + k));
    end
    expect_reg("R9 top of full stack", 8'h18, 32'd67);
    bus_write(8'h38, 32'h0);
    expect_reg("R10 one pop", 8'h18, 32'd66);
    for (int k = 0; k < 7; k++) bus_write(8'h38, 32'h0);
    expect_reg("R10 fully unwound", 8'h18, 32'h0);
    bus_write(8'h00, 32'd60);
    bus_write(8'h4C, 32'h1);
    expect_irq("R10 lowest prio after unwind", 1'b1);
    expect_reg("R7 vector 60", 8'h10, vec_of(60));
    bus_write(8'h38, 32'h0);
    for (int k = 0; k < 8; k++) off(60 + k);
  endtask

  task automatic t_polarity;
    src[70] = 1'b1;
    setup(70, T_FALL, 3, 1'b1);
    expect_irq("R4 high line no fall", 1'b0);
    src[70] = 1'b0;
    expect_irq("R4 falling latched", 1'b1);
    expect_reg("R5 word2 bit6", 8'h28, 32'h40);
    expect_reg("R7 falling vector", 8'h10, vec_of(70));
    bus_write(8'h38, 32'h0);
    off(70);
    setup(71, T_LOW, 2, 1'b0);
    expect_reg("R4 active low pending", 8'h28, 32'h80);
    src[71] = 1'b1;
    repeat (3) @(negedge clk);
    expect_reg("R4 active low released", 8'h28, 32'h0);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_level();
    t_edge_ack();
    t_prio_nest();
    t_spurious();
    t_clear();
    t_unwind();
    t_polarity();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule